// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Interface

This block is the digital front end of a two-channel 8-bit voltage DAC. A host writes it over a three-wire serial link made of an active-low select, a serial clock and a data line. Each write is a 16-bit frame. The first byte carries control bits and the second byte carries a data value. The control byte is not decoded. Each control bit acts on its own: it loads the data byte into channel A, loads it into channel B, or writes the power-down state of one channel.

Nothing takes effect while bits are arriving. The frame is applied on the rising edge of the select line, and only if exactly 16 bits were clocked in. The block keeps one stored code per channel and one shutdown flag per channel. The code it drives to each converter ladder is the stored code, or zero while that channel is shut down. The stored code is kept through shutdown, so bringing a channel back needs no rewrite.

The serial clock may run freely. It must make at least one rising edge while the select line is high between frames, because that edge clears the bit count.

Top module: `dual_dac_serial_front`

## Requirements
- R1: After reset both stored codes are 0x00, both shutdown flags are 0, and both output codes are 0x00.
- R2: While cs_n is high, serial clock edges shift nothing and the bit count stays at zero. Data toggled during that time has no effect on a later frame.
- R3: Data is sampled on rising sclk edges while cs_n is low, most significant bit first. The first 8 bits form the control byte (bits 7..0) and the last 8 bits form the data byte.
- R4: Stored codes and shutdown flags change only on a rising edge of cs_n that ends a frame of exactly 16 bits.
- R5: Control bit 7 loads the data byte into channel A and control bit 6 loads it into channel B. When both bits are set, both channels receive the same byte from that frame.
- R6: Every valid frame writes both shutdown flags. Control bit 5 sets the flag for channel A and bit 4 sets it for channel B; a 0 in either bit releases that channel.
- R7: While a channel's shutdown flag is 1, its output code is 0x00 and its stored code is kept. When the flag returns to 0, the output shows the stored code again.
- R8: A load bit set while a channel is in shutdown still updates the stored code. The new value appears at the output once shutdown is released.
- R9: Control bits 3..0 have no effect.
- R10: A frame that ends after any bit count other than 16 (fewer, or more) is discarded. Stored codes and shutdown flags are left as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| cs_n | input | 1 | Active-low frame select; its rising edge applies the frame |
| sdi | input | 1 | Serial data in, MSB first |
| code_a | output | 8 | Code driven to the channel A ladder |
| code_b | output | 8 | Code driven to the channel B ladder |
| shut_a | output | 1 | Channel A shutdown flag |
| shut_b | output | 1 | Channel B shutdown flag |

## Verification
Some properties are checked by assertions on every serial clock edge:
- the bit count clears and holds while the select line is high;
- each sampled data bit lands in the shift register;
- stored state stays unchanged across any clock interval with no select rising edge;
- a shut-down channel drives a zero code.

The bench's scenarios are needed for the rest:
- the meaning of each control bit;
- that the same data byte goes to both channels;
- that the stored value survives shutdown and a load made during shutdown;
- that frames too short or too long are discarded.

The bench shows these by comparing the ports with its own frame model after each clock.

// File: rtl/ddsf_pkg.sv
package ddsf_pkg;
   // Position of the load bit for channel ch inside the control byte
   function automatic int unsigned load_pos(input int unsigned ctrl_w, input int unsigned ch);
      return ctrl_w - 1 - ch;
   endfunction

   // Position of the shutdown bit for channel ch inside the control byte
   function automatic int unsigned shut_pos(input int unsigned ctrl_w, input int unsigned nch,
                                            input int unsigned ch);
      return ctrl_w - 1 - nch - ch;
   endfunction
endpackage

// File: rtl/ddsf_shifter.sv
module ddsf_shifter #(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned CNT_W   = 5
) (
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               sdi,
   output logic [FRAME_W-1:0] word,
   output logic [CNT_W-1:0]   count
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

   initial begin
      if ((FRAME_W + 1) >= (1 << CNT_W))
         $error("ddsf_shifter: CNT_W too narrow for FRAME_W");
   end

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         count <= '0;
      end else if (cs_n) begin
         count <= '0;
      end else begin
         word <= {word[FRAME_W-2:0], sdi};
         if (count != CNT_SAT)
            count <= count + 1'b1;
      end
   end

   // R2: an idle select line leaves the count at zero on the next edge
   a_r2_idle_clears: assert property (@(posedge sclk) disable iff (!rst_n)
      cs_n |=> (count == '0));

   // R3: the bit sampled on this edge becomes the newest bit of the word
   a_r3_shift_in: assert property (@(posedge sclk) disable iff (!rst_n)
      !cs_n |=> (word[0] == $past(sdi)) && (word[FRAME_W-1:1] == $past(word[FRAME_W-2:0])));
endmodule

// File: rtl/ddsf_apply.sv
module ddsf_apply #(
   parameter int unsigned CTRL_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NCH    = 2,
   parameter int unsigned CNT_W  = 5
) (
   input  logic                      rst_n,
   input  logic                      cs_n,
   input  logic [CTRL_W+DATA_W-1:0]  word,
   input  logic [CNT_W-1:0]          count,
   output logic [NCH-1:0][DATA_W-1:0] stored,
   output logic [NCH-1:0]            shut
);
   import ddsf_pkg::*;
   localparam int unsigned FRAME_W = CTRL_W + DATA_W;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic [CTRL_W-1:0] ctrl;
   logic [DATA_W-1:0] data;
   logic              full;

   assign ctrl = word[FRAME_W-1:DATA_W];
   assign data = word[DATA_W-1:0];
   assign full = (count == CNT_FULL);

   initial begin
      if (2 * NCH > CTRL_W)
         $error("ddsf_apply: control byte too narrow for %0d channels", NCH);
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam int unsigned LP = load_pos(CTRL_W, ch);
      localparam int unsigned SP = shut_pos(CTRL_W, NCH, ch);

      always_ff @(posedge cs_n or negedge rst_n) begin
         if (!rst_n) begin
            stored[ch] <= '0;
            shut[ch]   <= 1'b0;
         end else if (full) begin
            if (ctrl[LP])
               stored[ch] <= data;
            shut[ch] <= ctrl[SP];
         end
      end
   end
endmodule

// File: rtl/ddsf_outmux.sv
module ddsf_outmux #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          HOLD_OFF = 1'b1
) (
   input  logic [DATA_W-1:0] stored,
   input  logic              shut,
   output logic [DATA_W-1:0] code
);
   if (HOLD_OFF) begin : g_force_zero
      assign code = shut ? '0 : stored;
   end else begin : g_pass
      logic unused_shut;
      assign unused_shut = shut;
      assign code = stored;
   end
endmodule

// File: rtl/dual_dac_serial_front.sv
module dual_dac_serial_front #(
   parameter int unsigned CTRL_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b,
   output logic              shut_a,
   output logic              shut_b
);
   localparam int unsigned NCH     = 2;
   localparam int unsigned FRAME_W = CTRL_W + DATA_W;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);

   logic [FRAME_W-1:0]         word;
   logic [CNT_W-1:0]           count;
   logic [NCH-1:0][DATA_W-1:0] stored;
   logic [NCH-1:0]             shut;
   logic [NCH-1:0][DATA_W-1:0] code;

   ddsf_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .word(word), .count(count)
   );

   ddsf_apply #(.CTRL_W(CTRL_W), .DATA_W(DATA_W), .NCH(NCH), .CNT_W(CNT_W)) u_apply (
      .rst_n(rst_n), .cs_n(cs_n), .word(word), .count(count),
      .stored(stored), .shut(shut)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_out
      ddsf_outmux #(.DATA_W(DATA_W), .HOLD_OFF(1'b1)) u_mux (
         .stored(stored[ch]), .shut(shut[ch]), .code(code[ch])
      );
   end

   assign code_a = code[0];
   assign code_b = code[1];
   assign shut_a = shut[0];
   assign shut_b = shut[1];

   // R4: with the select held high across an interval, no stored state moves
   a_r4_only_on_select_rise: assert property (@(posedge sclk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> ($stable(stored) && $stable(shut)));

   // R7: a channel in shutdown drives a zero code
   a_r7_shut_a_zero: assert property (@(posedge sclk) disable iff (!rst_n)
      shut_a |-> (code_a == '0));
   a_r7_shut_b_zero: assert property (@(posedge sclk) disable iff (!rst_n)
      shut_b |-> (code_b == '0));
endmodule

// File: tb/dual_dac_serial_front_test.sv
`timescale 1ns/1ps
module dual_dac_serial_front_test;
   logic       rst_n = 1'b0;
   logic       sclk  = 1'b0;
   logic       cs_n  = 1'b1;
   logic       sdi   = 1'b0;
   logic [7:0] code_a, code_b;
   logic       shut_a, shut_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural reference state
   logic [7:0] m_reg_a = 8'h00, m_reg_b = 8'h00;
   bit         m_sd_a = 0, m_sd_b = 0;
   bit         m_bits[$];

   dual_dac_serial_front uut (
      .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .code_a(code_a), .code_b(code_b), .shut_a(shut_a), .shut_b(shut_b)
   );

   always #10 sclk = ~sclk;   // 50 MHz

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   // Compare every port with the model each cycle, a quarter period after the falling edge
   always begin
      @(negedge sclk);
      #5;
      if (rst_n && !done) begin
         chk("R5/R7 code_a", code_a, m_sd_a ? 8'h00 : m_reg_a);
         chk("R5/R7 code_b", code_b, m_sd_b ? 8'h00 : m_reg_b);
         chk("R6 shut_a", {7'd0, shut_a}, {7'd0, m_sd_a});
         chk("R6 shut_b", {7'd0, shut_b}, {7'd0, m_sd_b});
      end
   end

   // Apply a finished frame to the model: R4, R10 (only 16 bits count), R5, R6, R8, R9
   task automatic model_close();
      logic [15:0] w;
      if (m_bits.size() == 16) begin
         w = '0;
         foreach (m_bits[i]) w = {w[14:0], m_bits[i]};   // R3 MSB first
         if (w[15]) m_reg_a = w[7:0];
         if (w[14]) m_reg_b = w[7:0];
         m_sd_a = w[13];
         m_sd_b = w[12];
      end
      m_bits.delete();
   endtask

   task automatic send(input logic [15:0] w, input int nbits);
      @(negedge sclk);
      cs_n = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         sdi = w[15 - (i % 16)];
         m_bits.push_back(sdi);
         @(negedge sclk);
      end
      cs_n = 1'b1;
      model_close();
      @(negedge sclk);
      @(negedge sclk);
   endtask

   // R2: clock keeps running and data toggles while cs_n is high
   task automatic idle_noise(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge sclk);
         sdi = i[0];
      end
   endtask

   initial begin
      #50;
      // R1: reset state
      chk("R1 code_a", code_a, 8'h00);
      chk("R1 code_b", code_b, 8'h00);
      chk("R1 shut", {6'd0, shut_b, shut_a}, 8'h00);
      @(negedge sclk);
      rst_n = 1'b1;
      idle_noise(5);                 // R2
      send(16'h805A, 16);            // R5 load A only, R3 order
      send(16'h40C3, 16);            // R5 load B only
      idle_noise(7);                 // R2 noise between frames
      send(16'hC077, 16);            // R5 same byte to both
      send(16'h20FF, 16);            // R6/R7 shut A, no load
      send(16'h0000, 16);            // R7 restore A from stored value
      send(16'hF011, 16);            // R8 load both while entering shutdown
      send(16'h1022, 16);            // R6 A released, B shut
      send(16'h0000, 16);            // R8 B shows value loaded during shutdown
      send(16'h0FAA, 16);            // R9 low control bits do nothing
      send(16'h80EE, 15);            // R10 short frame discarded
      send(16'h80EE, 17);            // R10 long frame discarded
      send(16'h40DD, 8);             // R10 half frame discarded
      send(16'h3000, 33);            // R10 very long frame discarded
      send(16'h80EE, 16);            // R4 valid frame after aborts
      done = 1;
      #1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule